// File: doc/BRIEF.md
# Functional-Unit Power-Gating Sleep Controller

This block produces one sleep signal for each of the four execute-stage functional units of a five-stage in-order 32-bit pipeline. The four units are the common ALU, the shifter, the multiplier and the divider. The block looks at the instruction in the fetch stage to find the unit that instruction will need. It wakes that unit one cycle ahead of its execute cycle, so a unit never needs an explicit instruction to wake it.

Sleep decisions depend on a 2-bit gating mode for each unit, held in a register that software writes. In hint-driven mode, the high six opcode bits of each completing register-type instruction tell the block what to do with the target unit. One hint value gates the unit off after the operation. The other hint value holds the unit on until a gating hint with the same function code completes. In hint-driven mode any pipeline stall or cache miss also gates all units off. In miss-only mode a unit is gated only by an outstanding cache miss. The remaining two encodings keep every unit powered.

For each unit, a saturating counter records the total number of cycles that unit has spent gated off. Software can use it to judge whether the selected mode pays off.

Top module: `pg_sleep_ctrl`

## Requirements
- R1: After reset, every unit's mode field is 10, so the mode register reads 8'hAA. All sleep outputs are 0 and all sleep-cycle counters are 0.
- R2: Decode rules. Bits 31:26 are the opcode and bits 5:0 are the function code. Opcode 000000 and opcode 100111 mark a register-type instruction, and the function code then picks the unit: 000xxx is the shifter, 01100x the multiplier, 01101x the divider, 10xxxx the ALU, and any other code no unit. Every other opcode uses the ALU. Unit indices are bit 0 ALU, bit 1 shifter, bit 2 multiplier, bit 3 divider.
- R3: A valid fetched instruction that needs unit u clears sleep[u] at the next clock edge. This wake overrides any sleep request for u in the same cycle.
- R4: In mode 00, a completing register-type instruction with opcode 000000 that targets the shifter, multiplier or divider sets that unit's sleep output at the next edge.
- R5: A completing instruction with opcode 100111 marks its unit as held on and records its function code. While the unit is held, an opcode-000000 completion with a different function code leaves the unit awake. An opcode-000000 completion with the recorded code gates the unit and releases the hold.
- R6: In mode 00, a stall or a cache miss gates every unit, the ALU included, at the next edge. A unit woken by fetch in that same cycle is the exception.
- R7: In mode 01, only a cache miss gates a unit. Stalls and opcode hints have no effect.
- R8: In modes 10 and 11, a unit's sleep output is 0 from the edge after the mode is in the register. No stall, miss or hint gates it.
- R9: The ALU is never gated by an opcode-000000 completion.
- R10: Each unit has its own mode field at bits [2u+1:2u] of the mode register. A write strobe loads the register at the clock edge. The read-back port shows the register contents at all times.
- R11: A unit's counter increases by one for each cycle its sleep output is 1 and holds otherwise. It saturates at 2^CNT_W-1.
- R12: A gated unit stays gated until a fetch wakes it, even after a stall or miss has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch-stage instruction is valid |
| fetch_instr | input | 32 | Instruction in the fetch stage |
| exdone_valid | input | 1 | An instruction completes execute this cycle |
| exdone_instr | input | 32 | Instruction completing execute |
| pipe_stall | input | 1 | Any pipeline stall event |
| cache_miss | input | 1 | Instruction or data cache miss outstanding |
| pol_we | input | 1 | Mode register write strobe |
| pol_wdata | input | 8 | Mode register write data, 2 bits per unit |
| pol_rdata | output | 8 | Mode register read-back |
| unit_sleep | output | 4 | Sleep output per unit (1 = gated off) |
| sleep_cycles | output | 4*CNT_W | Per-unit saturating sleep-cycle counters, unit u at [u*CNT_W +: CNT_W] |

## Verification
The hold state of a unit and its recorded function code are not visible at the ports. A fault in either one shows up only later, at the first opcode-000000 completion for that unit, when the unit either sleeps when it should not or stays awake when it should sleep. That is why the directed sequence pairs hold and release with matching and non-matching codes. A wrong mode or sleep bit shows on unit_sleep at the next edge. From then on the sleep-cycle counter drifts by one per cycle, so an error that touches unit_sleep for only a single cycle still leaves a permanent trace on the counters.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NUM_UNITS = 4;
  localparam int U_ALU = 0;
  localparam int U_SHF = 1;
  localparam int U_MUL = 2;
  localparam int U_DIV = 3;
  localparam int POL_W = 2 * NUM_UNITS;

  localparam logic [5:0] OP_GATE_HINT = 6'b000000;
  localparam logic [5:0] OP_HOLD_HINT = 6'b100111;

  typedef enum logic [1:0] {
    MODE_HINT  = 2'b00,
    MODE_MISS  = 2'b01,
    MODE_NEVER = 2'b10,
    MODE_RSVD  = 2'b11
  } gate_mode_e;

  typedef struct packed {
    logic [NUM_UNITS-1:0] need;
    logic                 gate_hint;
    logic                 hold_hint;
    logic [5:0]           funct;
  } op_class_t;

  function automatic logic [NUM_UNITS-1:0] unit_of(input logic [5:0] op, input logic [5:0] fn);
    logic [NUM_UNITS-1:0] m;
    m = '0;
    if (op != OP_GATE_HINT && op != OP_HOLD_HINT) begin
      m[U_ALU] = 1'b1;
    end else if (fn[5:3] == 3'b000) begin
      m[U_SHF] = 1'b1;
    end else if (fn[5:2] == 4'b0110) begin
      if (fn[1]) m[U_DIV] = 1'b1;
      else       m[U_MUL] = 1'b1;
    end else if (fn[5:4] == 2'b10) begin
      m[U_ALU] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic mode_allows_gating(input gate_mode_e md);
    return (md == MODE_HINT) || (md == MODE_MISS);
  endfunction
endpackage

// File: rtl/pg_decode.sv
module pg_decode
  import pg_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output op_class_t   cls
);
  logic [5:0] op;
  logic [5:0] fn;
  logic       unused_mid;

  assign op         = instr[31:26];
  assign fn         = instr[5:0];
  assign unused_mid = ^instr[25:6];

  always_comb begin
    cls.need      = valid ? unit_of(op, fn) : '0;
    cls.gate_hint = valid && (op == OP_GATE_HINT) && (|unit_of(op, fn));
    cls.hold_hint = valid && (op == OP_HOLD_HINT) && (|unit_of(op, fn));
    cls.funct     = fn;
  end
endmodule

// File: rtl/pg_mode_reg.sv
module pg_mode_reg
  import pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [POL_W-1:0] wdata,
  output logic [POL_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= {NUM_UNITS{MODE_NEVER}};
    else if (we) mode_q <= wdata;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode_q == $past(wdata))); // R10
endmodule

// File: rtl/pg_unit_ctl.sv
module pg_unit_ctl
  import pg_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter bit AUTO_SLEEP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             wake,
  input  logic             done_hit,
  input  logic             done_gate_hint,
  input  logic             done_hold_hint,
  input  logic [5:0]       done_funct,
  input  logic             stall,
  input  logic             miss,
  output logic             sleep,
  output logic [CNT_W-1:0] sleep_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  gate_mode_e       md;
  logic             hold_q;
  logic [5:0]       hold_fn_q;
  logic             sleep_q;
  logic [CNT_W-1:0] cnt_q;

  // named internal events
  logic hold_match;
  logic gate_hint_ev;
  logic after_use_req;
  logic sleep_req;
  logic gate_off;
  logic sleep_d;

  assign md            = gate_mode_e'(mode);
  assign hold_match    = hold_q && (hold_fn_q == done_funct);
  assign gate_hint_ev  = done_hit && done_gate_hint && (!hold_q || hold_match);
  assign after_use_req = AUTO_SLEEP && gate_hint_ev;
  assign gate_off      = !mode_allows_gating(md);

  always_comb begin
    unique case (md)
      MODE_HINT: sleep_req = after_use_req || stall || miss;
      MODE_MISS: sleep_req = miss;
      default:   sleep_req = 1'b0;
    endcase
  end

  always_comb begin
    if (gate_off)       sleep_d = 1'b0;
    else if (wake)      sleep_d = 1'b0;
    else if (sleep_req) sleep_d = 1'b1;
    else                sleep_d = sleep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q   <= 1'b0;
      hold_q    <= 1'b0;
      hold_fn_q <= '0;
      cnt_q     <= '0;
    end else begin
      sleep_q <= sleep_d;
      if (sleep_q) cnt_q <= sat_inc(cnt_q);
      if (done_hit && done_hold_hint) begin
        hold_q    <= 1'b1;
        hold_fn_q <= done_funct;
      end else if (done_hit && done_gate_hint && hold_match) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign sleep     = sleep_q;
  assign sleep_cnt = cnt_q;

  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !sleep_q); // R3
  AST_NEVER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> !sleep_q); // R8
  AST_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !miss && !sleep_q) |=> !sleep_q); // R7
  AST_ALU_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (!AUTO_SLEEP && !stall && !miss && !sleep_q) |=> !sleep_q); // R9
  AST_STAYS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !wake && !mode[1]) |=> sleep_q); // R12
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pg_sleep_ctrl.sv
module pg_sleep_ctrl
  import pg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  input  logic [31:0]                fetch_instr,
  input  logic                       exdone_valid,
  input  logic [31:0]                exdone_instr,
  input  logic                       pipe_stall,
  input  logic                       cache_miss,
  input  logic                       pol_we,
  input  logic [POL_W-1:0]           pol_wdata,
  output logic [POL_W-1:0]           pol_rdata,
  output logic [NUM_UNITS-1:0]       unit_sleep,
  output logic [NUM_UNITS*CNT_W-1:0] sleep_cycles
);
  op_class_t        fetch_cls;
  op_class_t        done_cls;
  logic [POL_W-1:0] mode_q;
  logic             unused_fetch_hints;

  pg_decode u_fetch_dec (.valid(fetch_valid),  .instr(fetch_instr),  .cls(fetch_cls));
  pg_decode u_done_dec  (.valid(exdone_valid), .instr(exdone_instr), .cls(done_cls));

  assign unused_fetch_hints = fetch_cls.gate_hint ^ fetch_cls.hold_hint ^ (^fetch_cls.funct);

  pg_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(pol_we), .wdata(pol_wdata), .mode_q(mode_q)
  );
  assign pol_rdata = mode_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    pg_unit_ctl #(
      .CNT_W     (CNT_W),
      .AUTO_SLEEP((u == U_ALU) ? 1'b0 : 1'b1)
    ) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (mode_q[2*u +: 2]),
      .wake          (fetch_cls.need[u]),
      .done_hit      (done_cls.need[u]),
      .done_gate_hint(done_cls.gate_hint),
      .done_hold_hint(done_cls.hold_hint),
      .done_funct    (done_cls.funct),
      .stall         (pipe_stall),
      .miss          (cache_miss),
      .sleep         (unit_sleep[u]),
      .sleep_cnt     (sleep_cycles[u*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/tb_pg_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pg_sleep_ctrl;
  localparam int CW   = 8;
  localparam int CMAX = 255;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fv, ev, st, ms, we;
  logic [31:0] fi, ei;
  logic [7:0]  wd;
  logic [7:0]  rdata;
  logic [3:0]  slp;
  logic [31:0] cyc;

  pg_sleep_ctrl #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_instr(fi),
    .exdone_valid(ev), .exdone_instr(ei), .pipe_stall(st), .cache_miss(ms),
    .pol_we(we), .pol_wdata(wd), .pol_rdata(rdata), .unit_sleep(slp), .sleep_cycles(cyc)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  logic [7:0]  m_pol;
  logic [3:0]  m_sleep, m_hold;
  logic [5:0]  m_hfn [4];
  int unsigned m_cnt [4];

  function automatic logic [3:0] tb_need(input logic [31:0] i);
    logic [5:0] op = i[31:26];
    logic [5:0] f  = i[5:0];
    if (op != 6'h00 && op != 6'h27) return 4'b0001;
    if (f <= 6'd7) return 4'b0010;
    if (f == 6'd24 || f == 6'd25) return 4'b0100;
    if (f == 6'd26 || f == 6'd27) return 4'b1000;
    if (f >= 6'd32 && f <= 6'd47) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [5:0] f);
    return {op, 20'h12345, f};
  endfunction

  function automatic logic [31:0] rnd_ins();
    logic [5:0] op;
    logic [5:0] f;
    int k = $urandom % 8;
    op = (k < 3) ? 6'h00 : (k < 6) ? 6'h27 : 6'($urandom % 64);
    case ($urandom % 5)
      0: f = 6'($urandom % 8);
      1: f = 6'(24 + $urandom % 4);
      2: f = 6'(32 + $urandom % 16);
      3: f = 6'($urandom % 64);
      default: f = 6'(24 + $urandom % 2);
    endcase
    return {op, 20'($urandom), f};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [3:0]  ns, nh;
    logic [5:0]  nhf [4];
    int unsigned nc [4];
    logic [3:0]  nf, ne;
    logic [5:0]  eop, efn;
    logic [31:0] flat;
    nf  = fv ? tb_need(fi) : 4'b0;
    ne  = ev ? tb_need(ei) : 4'b0;
    eop = ei[31:26];
    efn = ei[5:0];
    for (int u = 0; u < 4; u++) begin
      logic [1:0] p;
      logic gh, hh, allow, req;
      p     = m_pol[2*u +: 2];
      gh    = ne[u] && eop == 6'h00;
      hh    = ne[u] && eop == 6'h27;
      allow = gh && (!m_hold[u] || m_hfn[u] == efn);
      if (p == 2'b00)      req = (u != 0 && allow) || st || ms;
      else if (p == 2'b01) req = ms;
      else                 req = 1'b0;
      if (p[1])       ns[u] = 1'b0;
      else if (nf[u]) ns[u] = 1'b0;
      else if (req)   ns[u] = 1'b1;
      else            ns[u] = m_sleep[u];
      nh[u]  = m_hold[u];
      nhf[u] = m_hfn[u];
      if (hh) begin
        nh[u] = 1'b1; nhf[u] = efn;
      end else if (gh && m_hold[u] && m_hfn[u] == efn) begin
        nh[u] = 1'b0;
      end
      nc[u] = (m_sleep[u] && m_cnt[u] < CMAX) ? m_cnt[u] + 1 : m_cnt[u];
    end
    @(posedge clk);
    if (we) m_pol = wd;
    m_sleep = ns;
    m_hold  = nh;
    for (int u = 0; u < 4; u++) begin
      m_hfn[u] = nhf[u];
      m_cnt[u] = nc[u];
    end
    #1;
    for (int u = 0; u < 4; u++) flat[u*8 +: 8] = m_cnt[u][7:0];
    chk(tag, "sleep", 64'(slp), 64'(m_sleep));
    chk(tag, "cycles", 64'(cyc), 64'(flat));
    chk(tag, "mode", 64'(rdata), 64'(m_pol));
  endtask

  task automatic idle();
    fv = 0; ev = 0; st = 0; ms = 0; we = 0;
    fi = 32'h0; ei = 32'h0; wd = 8'h0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    m_pol = 8'hAA; m_sleep = 4'b0; m_hold = 4'b0;
    for (int u = 0; u < 4; u++) begin m_hfn[u] = 6'h0; m_cnt[u] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", "reset sleep", 64'(slp), 64'h0);
    chk("R1", "reset mode", 64'(rdata), 64'hAA);
    chk("R1", "reset cycles", 64'(cyc), 64'h0);

    // R10: write all-hint mode
    we = 1; wd = 8'h00; step("R10"); we = 0;
    chk("R10", "readback", 64'(rdata), 64'h00);
    // R4: multiplier gated after opcode-000000 completion
    ev = 1; ei = mk(6'h00, 6'd24); step("R4"); idle();
    chk("R4", "mul gated", 64'(slp), 64'h4);
    // R9: ALU not gated after use
    ev = 1; ei = mk(6'h00, 6'd32); step("R9"); idle();
    chk("R9", "alu awake", 64'(slp), 64'h4);
    // R3: wake beats stall
    fv = 1; fi = mk(6'h00, 6'd24); st = 1; step("R3"); idle();
    chk("R3", "wake wins", 64'(slp), 64'hB);
    // R6: stall gates all including ALU
    st = 1; step("R6"); idle();
    chk("R6", "stall all", 64'(slp), 64'hF);
    fv = 1; fi = mk(6'h00, 6'd0); step("R3"); idle();
    chk("R3", "shifter wake", 64'(slp), 64'hD);
    fv = 1; fi = mk(6'h00, 6'd32); step("R3"); idle();
    chk("R3", "alu wake", 64'(slp), 64'hC);
    // R5: hold and release
    fv = 1; fi = mk(6'h00, 6'd24); step("R5"); idle();
    chk("R5", "mul wake", 64'(slp), 64'h8);
    ev = 1; ei = mk(6'h27, 6'd24); step("R5"); idle();
    chk("R5", "hold set", 64'(slp), 64'h8);
    ev = 1; ei = mk(6'h00, 6'd25); step("R5"); idle();
    chk("R5", "other code ignored", 64'(slp), 64'h8);
    ev = 1; ei = mk(6'h00, 6'd24); step("R5"); idle();
    chk("R5", "same code gates", 64'(slp), 64'hC);
    fv = 1; fi = mk(6'h00, 6'd24); step("R5"); idle();
    ev = 1; ei = mk(6'h00, 6'd25); step("R5"); idle();
    chk("R5", "hold released", 64'(slp), 64'hC);
    // R2: decode of other opcodes and unused codes
    st = 1; step("R2"); idle();
    fv = 1; fi = mk(6'h23, 6'd0); step("R2"); idle();
    chk("R2", "load uses alu", 64'(slp), 64'hE);
    fv = 1; fi = mk(6'h00, 6'd16); step("R2"); idle();
    chk("R2", "unused code", 64'(slp), 64'hE);
    fv = 1; fi = mk(6'h27, 6'd5); step("R2"); idle();
    chk("R2", "hold-op shift", 64'(slp), 64'hC);
    // R7: miss-only mode
    we = 1; wd = 8'h55; step("R7"); idle();
    fv = 1; fi = mk(6'h00, 6'd26); step("R7"); idle();
    chk("R7", "div wake", 64'(slp), 64'h4);
    ev = 1; ei = mk(6'h00, 6'd26); step("R7"); idle();
    chk("R7", "hint ignored", 64'(slp), 64'h4);
    st = 1; step("R7"); idle();
    chk("R7", "stall ignored", 64'(slp), 64'h4);
    ms = 1; step("R7"); idle();
    chk("R7", "miss gates", 64'(slp), 64'hF);
    // R12: stays gated after miss ends
    step("R12"); step("R12"); step("R12");
    chk("R12", "still gated", 64'(slp), 64'hF);
    // R8: never-gate modes
    we = 1; wd = 8'hAA; step("R8"); idle();
    chk("R8", "write edge", 64'(slp), 64'hF);
    step("R8");
    chk("R8", "forced awake", 64'(slp), 64'h0);
    st = 1; ms = 1; step("R8"); idle();
    chk("R8", "requests ignored", 64'(slp), 64'h0);
    we = 1; wd = 8'hFF; step("R8"); idle();
    ms = 1; step("R8"); idle();
    chk("R8", "reserved mode", 64'(slp), 64'h0);
    // R10: per-unit fields
    we = 1; wd = 8'h06; step("R10"); idle();
    st = 1; step("R10"); idle();
    chk("R10", "mixed modes", 64'(slp), 64'hC);
    // R11: saturation
    we = 1; wd = 8'h00; step("R11"); idle();
    st = 1;
    for (int k = 0; k < 300; k++) step("R11");
    idle();
    chk("R11", "saturated", 64'(cyc), 64'hFFFF_FFFF);
    step("R11");
    chk("R11", "held at max", 64'(cyc), 64'hFFFF_FFFF);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      fv = ($urandom % 3) != 0;
      fi = rnd_ins();
      ev = ($urandom % 3) != 0;
      ei = rnd_ins();
      st = ($urandom % 8) == 0;
      ms = ($urandom % 16) == 0;
      we = ($urandom % 40) == 0;
      wd = 8'($urandom);
      step("R4");
    end
    idle();
    finish_run();
  end
endmodule